// File: doc/BRIEF.md
# Space Vector PWM Modulator

This block turns a direct/quadrature voltage command into three compare words for the PWM timers of a three-phase bridge. It takes the command and the sine and cosine of the rotor's electrical angle. First it rotates the command back into the stationary alpha/beta frame. Then it splits the alpha/beta vector into three phase duties using a mask-driven decomposition with no branches. In every result one phase is pinned to zero, and the other two carry the whole vector. Depending on the region, those two are scaled by 1/√3 or by 2/√3.

Each output word holds a compare value of up to 14 bits, clipped into range, plus a channel-enable flag in bit 14. A one-cycle `start` launches a conversion, and only an idle block accepts it. Exactly three clock edges after the accepting edge, a one-cycle `done` marks the new words. The words then hold until the next conversion completes. The PWM counter, dead-time insertion and the angle source belong to other blocks.

Top module: `svpwm_modulator`

## Requirements
- R1: While `rst` is high and after it falls, `done` is 0 and all three compare words are 0 until the first conversion completes.
- R2: Command fields: D is the signed value in `cmd_dq[31:16]`, and Q is the signed value in `cmd_dq[15:0]`.
- R3: The rotation computes alpha = D·cos − Q·sin and beta = D·sin + Q·cos as signed 32-bit products. Sine and cosine are in Q16, so 65536 = 1.0, and all arithmetic wraps at 32 bits.
- R4: The scaled beta term B is 37837 × (beta >>> 16), computed in 32 bits.
- R5: When alpha < 0 and (−alpha − 1) − |B| ≥ 0, phase 1 is 0, phase 2 is (B − alpha) >>> 16 and phase 3 is (−B − alpha) >>> 16.
- R6: Otherwise, the sign of beta decides which phase is zeroed. For beta ≥ 0, phase 3 is 0, phase 2 is B >>> 15 and phase 1 is (alpha + B) >>> 16. For beta < 0, phase 2 is 0, phase 3 is (−B) >>> 15 and phase 1 is (alpha − B) >>> 16.
- R7: Each phase value is clipped to 0..0x3FFF before it is packed.
- R8: Each output word has bit 14 set as the enable flag, bit 15 clear, and the clipped value in bits 13:0.
- R9: `cmp_a` carries phase 2, `cmp_b` carries phase 3 and `cmp_c` carries phase 1.
- R10: A `start` sampled while idle gives `done` high for exactly one cycle, after the third rising edge that follows the accepting edge. The new words appear in that same cycle.
- R11: A `start` seen before the block is idle again, including in the `done` cycle, is ignored. It produces no extra `done`, and the words are unchanged outside `done` cycles.
- R12: In every completed result at least one of the three compare values (bits 13:0) is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Conversion request, accepted only when idle |
| cmd_dq | input | 32 | Packed command: D in bits 31:16, Q in bits 15:0 |
| sin_q16 | input | 18 | Sine of electrical angle, signed Q16 |
| cos_q16 | input | 18 | Cosine of electrical angle, signed Q16 |
| done | output | 1 | One-cycle strobe marking fresh compare words |
| cmp_a | output | 16 | Phase 2 compare word with enable flag |
| cmp_b | output | 16 | Phase 3 compare word with enable flag |
| cmp_c | output | 16 | Phase 1 compare word with enable flag |

## Verification
The bench targets the border between the negative-alpha region and the rest, with pure negative D against zero beta. A wrong magnitude test there would leave phase 1 carrying the vector instead of zero. It also drives positive and negative pure Q, where a swapped beta-sign mask would zero the wrong phase and a 16-bit shift on the survivor would halve it. Large commands hit the upper clip, where a missing clamp would corrupt the flag bit. Starts issued during a conversion and in its `done` cycle would, in a design with a loose idle test, show up as a second `done` or as overwritten words. Products near the 32-bit edge check that the wraparound matches.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;

    localparam int ACC_W    = 32;
    localparam int CMP_W    = 14;
    localparam int WORD_W   = 16;
    localparam int NUM_CH   = 3;
    localparam int FLAG_BIT = 14;

    // 1/(2*sqrt(3)/2) in Q16
    localparam logic signed [ACC_W-1:0] BETA_SCALE = 32'sd37837;

    localparam logic signed [ACC_W-1:0] CMP_MAX = (ACC_W'(1) <<< CMP_W) - 1;

    typedef logic signed [ACC_W-1:0] acc_t;

    typedef struct packed {
        acc_t alpha;
        acc_t beta;
    } ab_vec_t;

    typedef struct packed {
        acc_t ph1;
        acc_t ph2;
        acc_t ph3;
    } phase_set_t;

    typedef logic [WORD_W-1:0] cmp_word_t;

    function automatic cmp_word_t pack_phase(input acc_t v);
        cmp_word_t w;
        acc_t      c;
        if (v < 0)
            c = '0;
        else if (v > CMP_MAX)
            c = CMP_MAX;
        else
            c = v;
        w = '0;
        w[CMP_W-1:0] = c[CMP_W-1:0];
        w[FLAG_BIT]  = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/svpwm_rotate.sv
module svpwm_rotate
    import svpwm_pkg::*;
#(
    parameter int CMD_W  = 32,
    parameter int TRIG_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [TRIG_W-1:0] sin_v,
    input  logic [TRIG_W-1:0] cos_v,
    output ab_vec_t           ab_q
);
    localparam int HALF = CMD_W / 2;

    acc_t d_x, q_x, s_x, c_x;
    ab_vec_t ab_d;

    always_comb begin
        d_x = ACC_W'($signed(cmd[CMD_W-1:HALF]));
        q_x = ACC_W'($signed(cmd[HALF-1:0]));
        s_x = ACC_W'($signed(sin_v));
        c_x = ACC_W'($signed(cos_v));
        ab_d.alpha = d_x * c_x - q_x * s_x;
        ab_d.beta  = d_x * s_x + q_x * c_x;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ab_q <= '0;
        else if (load)
            ab_q <= ab_d;
    end

endmodule

// File: rtl/svpwm_sector.sv
module svpwm_sector
    import svpwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  ab_vec_t    ab,
    output phase_set_t ph_q
);
    acc_t bsc, sgn_a, sgn_b, mag_gap, lt_msk, s23;
    acc_t t1, t2, t3, t1f;
    phase_set_t ph_d;

    always_comb begin
        bsc     = BETA_SCALE * (ab.beta >>> 16);
        sgn_a   = {ACC_W{ab.alpha[ACC_W-1]}};
        sgn_b   = {ACC_W{ab.beta[ACC_W-1]}};
        // |alpha| (ones-complement) minus |scaled beta|
        mag_gap = (sgn_a ^ ab.alpha) - (sgn_b ^ (bsc + sgn_b));
        lt_msk  = {ACC_W{mag_gap[ACC_W-1]}};
        s23     = sgn_a & ~lt_msk;

        t1  = ab.alpha & s23;
        t2  = (bsc - t1) & (~sgn_b | s23);
        t3  = (-bsc - t1) & (sgn_b | s23);
        t1f = (ab.alpha + t2 + t3) & ~s23;

        ph_d.ph1 = t1f >>> 16;
        ph_d.ph2 = s23[0] ? (t2 >>> 16) : (t2 >>> 15);
        ph_d.ph3 = s23[0] ? (t3 >>> 16) : (t3 >>> 15);
    end

    always_ff @(posedge clk) begin
        if (rst)
            ph_q <= '0;
        else if (load)
            ph_q <= ph_d;
    end

endmodule

// File: rtl/svpwm_pack.sv
module svpwm_pack
    import svpwm_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load,
    input  phase_set_t                    ph,
    output logic [NUM_CH-1:0][WORD_W-1:0] words_q
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        acc_t src;
        // channel order: phase 2, phase 3, phase 1
        if (g == 0) begin : g_a
            assign src = ph.ph2;
        end else if (g == 1) begin : g_b
            assign src = ph.ph3;
        end else begin : g_c
            assign src = ph.ph1;
        end

        always_ff @(posedge clk) begin
            if (rst)
                words_q[g] <= '0;
            else if (load)
                words_q[g] <= pack_phase(src);
        end
    end

endmodule

// File: rtl/svpwm_modulator.sv
module svpwm_modulator
    import svpwm_pkg::*;
#(
    parameter int CMD_W  = 32,
    parameter int TRIG_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CMD_W-1:0]  cmd_dq,
    input  logic [TRIG_W-1:0] sin_q16,
    input  logic [TRIG_W-1:0] cos_q16,
    output logic              done,
    output logic [WORD_W-1:0] cmp_a,
    output logic [WORD_W-1:0] cmp_b,
    output logic [WORD_W-1:0] cmp_c
);
    localparam int STAGES = 3;

    logic [STAGES-1:0] stg_v;
    logic              idle, accept;
    ab_vec_t           ab;
    phase_set_t        ph;
    logic [NUM_CH-1:0][WORD_W-1:0] words;

    assign idle   = ~|stg_v;
    assign accept = start & idle;

    always_ff @(posedge clk) begin
        if (rst)
            stg_v <= '0;
        else
            stg_v <= {stg_v[STAGES-2:0], accept};
    end

    svpwm_rotate #(.CMD_W(CMD_W), .TRIG_W(TRIG_W)) u_rot (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .cmd   (cmd_dq),
        .sin_v (sin_q16),
        .cos_v (cos_q16),
        .ab_q  (ab)
    );

    svpwm_sector u_sec (
        .clk  (clk),
        .rst  (rst),
        .load (stg_v[0]),
        .ab   (ab),
        .ph_q (ph)
    );

    svpwm_pack u_pack (
        .clk     (clk),
        .rst     (rst),
        .load    (stg_v[1]),
        .ph      (ph),
        .words_q (words)
    );

    assign done  = stg_v[STAGES-1];
    assign cmp_a = words[0];
    assign cmp_b = words[1];
    assign cmp_c = words[2];

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        accept |-> ##3 done);                                          // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                               // R10
    AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(cmp_a) && $stable(cmp_b) && $stable(cmp_c))); // R11
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        done |-> (cmp_a[15:14] == 2'b01 && cmp_b[15:14] == 2'b01
                  && cmp_c[15:14] == 2'b01));                          // R8
    AST_ONE_ZERO: assert property (@(posedge clk) disable iff (rst)
        done |-> (cmp_a[13:0] == 0 || cmp_b[13:0] == 0
                  || cmp_c[13:0] == 0));                               // R12

endmodule

// File: tb/tb_svpwm_modulator.sv
module tb_svpwm_modulator;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] cmd_dq = '0;
    logic [17:0] sin_q16 = '0;
    logic [17:0] cos_q16 = '0;
    logic        done;
    logic [15:0] cmp_a, cmp_b, cmp_c;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    svpwm_modulator dut (
        .clk(clk), .rst(rst), .start(start), .cmd_dq(cmd_dq),
        .sin_q16(sin_q16), .cos_q16(cos_q16), .done(done),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c)
    );

    // ---------------- reference model ----------------
    function automatic int clip_pack(int v);
        int c;
        if (v < 0) c = 0;
        else if (v > 16383) c = 16383;
        else c = v;
        return c | 32'h4000;
    endfunction

    // returns {a, b, c} words
    function automatic logic [47:0] model(logic [31:0] cmd, logic [17:0] s, logic [17:0] c);
        int d, q, si, co, alp, bet, b, absb, gap, p1, p2, p3, wa, wb, wc;
        d  = int'($signed(cmd[31:16]));
        q  = int'($signed(cmd[15:0]));
        si = int'($signed(s));
        co = int'($signed(c));
        alp = d * co - q * si;                 // R3
        bet = d * si + q * co;
        b   = 37837 * (bet >>> 16);            // R4
        absb = (bet < 0) ? -b : b;
        gap  = (-alp - 1) - absb;
        if (alp < 0 && gap >= 0) begin         // R5
            p1 = 0;
            p2 = (b - alp) >>> 16;
            p3 = (-b - alp) >>> 16;
        end else if (bet < 0) begin            // R6
            p2 = 0;
            p3 = (-b) >>> 15;
            p1 = (alp - b) >>> 16;
        end else begin
            p3 = 0;
            p2 = b >>> 15;
            p1 = (alp + b) >>> 16;
        end
        wa = clip_pack(p2);                    // R9
        wb = clip_pack(p3);
        wc = clip_pack(p1);
        return {wa[15:0], wb[15:0], wc[15:0]};
    endfunction

    int          m_cnt = 0;
    logic [47:0] m_pend = '0;
    logic        exp_done = 1'b0;
    logic [47:0] exp_w = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; exp_done = 1'b0; exp_w = '0;
        end else begin
            exp_done = 1'b0;
            if (m_cnt == 0) begin
                if (start) begin
                    m_pend = model(cmd_dq, sin_q16, cos_q16);
                    m_cnt  = 3;
                end
            end else begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 1) begin
                    exp_done = 1'b1;
                    exp_w    = m_pend;
                end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            checks++;
            if (done !== exp_done) begin
                errors++;
                $display("FAIL R10 done actual %0b expected %0b", done, exp_done);
            end
            checks++;
            if ({cmp_a, cmp_b, cmp_c} !== exp_w) begin
                errors++;
                $display("FAIL R5 R6 R11 words actual %h expected %h",
                         {cmp_a, cmp_b, cmp_c}, exp_w);
            end
        end
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL R10 watchdog actual hung expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic convert(logic [31:0] cmd, int s, int c, output int lat);
        @(negedge clk);
        cmd_dq = cmd; sin_q16 = 18'(s); cos_q16 = 18'(c); start = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            lat++;
        end while (!done && lat < 10);
    endtask

    task automatic run_case(string tag, logic [31:0] cmd, int s, int c,
                            logic [15:0] ea, logic [15:0] eb, logic [15:0] ec);
        int lat;
        convert(cmd, s, c, lat);
        check_eq({tag, " latency R10"}, lat, 3);
        check_eq({tag, " cmp_a"}, {16'h0, cmp_a}, {16'h0, ea});
        check_eq({tag, " cmp_b"}, {16'h0, cmp_b}, {16'h0, eb});
        check_eq({tag, " cmp_c"}, {16'h0, cmp_c}, {16'h0, ec});
    endtask

    initial begin
        int lat;
        logic [15:0] ha, hb, hc;
        repeat (3) @(negedge clk);
        check_eq("R1 reset done", {31'h0, done}, 0);
        check_eq("R1 reset words", {cmp_a, cmp_b}, 0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 post-reset cmp_c", {16'h0, cmp_c}, 0);

        // R2 R3 R6 R9: D only, angle 0 -> phase 1 carries D
        run_case("R2 R3 R9 d+", {16'd1000, 16'd0}, 0, 65536, 16'h4000, 16'h4000, 16'h43E8);
        // R5: negative D, zero beta -> state 2/3, phase 1 zero
        run_case("R5 d-", {16'hFC18, 16'd0}, 0, 65536, 16'h43E8, 16'h43E8, 16'h4000);
        // R4 R6: positive Q -> phase 3 zeroed, survivor shifted by 15
        run_case("R4 R6 q+", {16'd0, 16'd1000}, 0, 65536, 16'h4482, 16'h4000, 16'h4241);
        // R6: negative Q -> phase 2 zeroed
        run_case("R6 q-", {16'd0, 16'hFC18}, 0, 65536, 16'h4000, 16'h4482, 16'h4241);
        // R2 R3: D rotated by 90 degrees behaves like positive Q on beta
        run_case("R2 R3 rot90", {16'd1000, 16'd0}, 65536, 0, 16'h4482, 16'h4000, 16'h4241);
        // R7 R8: large D saturates phase 1
        run_case("R7 R8 clip d", {16'd20000, 16'd0}, 0, 65536, 16'h4000, 16'h4000, 16'h7FFF);
        // R7: large Q saturates the surviving phase
        run_case("R7 clip q", {16'd0, 16'd30000}, 0, 65536, 16'h7FFF, 16'h4000, 16'h7FFF);

        // R11: starts while busy and in the done cycle are ignored
        @(negedge clk);
        cmd_dq = {16'd0, 16'd1000}; sin_q16 = '0; cos_q16 = 18'(65536); start = 1'b1;
        @(negedge clk);
        cmd_dq = {16'd5000, 16'd0};          // still high while busy
        @(negedge clk);
        @(negedge clk);
        check_eq("R11 first done", {31'h0, done}, 1);
        check_eq("R11 words from first", {16'h0, cmp_a}, 32'h4482);
        ha = cmp_a; hb = cmp_b; hc = cmp_c;
        start = 1'b0;
        repeat (4) @(negedge clk);
        check_eq("R11 no extra done", {31'h0, done}, 0);
        check_eq("R11 words held", {cmp_a, cmp_b}, {ha, hb});
        check_eq("R11 word c held", {16'h0, cmp_c}, {16'h0, hc});

        // mixed angles and wrap-prone operands, compared against the model
        for (int i = 0; i < 40; i++) begin
            int s, c;
            logic [31:0] cm;
            s  = (i * 9973) % 131072 - 65536;
            c  = ((i * 7919) + 20000) % 131072 - 65536;
            cm = {16'(i * 4099 - 32768), 16'(i * 2749 + 1234)};
            convert(cm, s, c, lat);
            check_eq("R10 latency sweep", lat, 3);
            checks++;
            if (cmp_a[13:0] != 0 && cmp_b[13:0] != 0 && cmp_c[13:0] != 0) begin
                errors++;
                $display("FAIL R12 no zero phase actual %h %h %h expected one zero",
                         cmp_a, cmp_b, cmp_c);
            end
        end
        convert({16'h8000, 16'h8000}, -65536, -65536, lat);
        check_eq("R3 wrap latency", lat, 3);

        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule